// File: doc/BRIEF.md
# SPI FIFO DMA Request Generator

This block drives the DMA read and write request lines for one SPI channel whose transmit and receive FIFOs are in use. A read request is raised when the receive FIFO holds at least a programmed byte count. A write request is raised when the transmit FIFO has fallen below a programmed byte count. Each request line can be masked on its own, and both lines depend on the channel enable.

A request does not follow the FIFO level continuously. It drops as soon as the first word of a burst has been moved over the bus. It then stays blocked until the whole burst has been serviced. The burst length in words is taken from the matching level field, converted from bytes to words by rounding up, with a floor of one word. Each bus access moves exactly one word and is reported to the block by a one-cycle strobe. Making the full number of accesses is the job of the DMA engine or firmware. Turning the channel off discards any burst in progress.

Top module: `spi_dma_req_gen`

## Requirements
- R1: With the channel enabled, the read mask set and no burst in progress, `dmaRdReq` goes high on the clock edge after one at which `rxOccBytes >= rxLevelBytes`. It does not go high while `rxOccBytes < rxLevelBytes`.
- R2: With the channel enabled, the write mask set and no burst in progress, `dmaWrReq` goes high on the clock edge after one at which `txOccBytes < txLevelBytes`. It does not go high while `txOccBytes >= txLevelBytes`. A write level of 0 therefore never raises the write request.
- R3: While a mask bit (`rdDmaEn` or `wrDmaEn`) is 0, its request is 0 from the next clock edge on. Clearing the mask while a request is pending withdraws that request.
- R4: A pulse on `rxWordRead` while `dmaRdReq` is high drops `dmaRdReq` at that same clock edge.
- R5: A pulse on `txWordWritten` while `dmaWrReq` is high drops `dmaWrReq` at that same clock edge.
- R6: The burst length is N = ceil(level / WORD_BYTES), with a minimum of 1, evaluated when the first access of the burst is made. The request stays low until N access strobes have been made in total, the first one included. With the trigger condition still true, the request rises again two clock edges after the edge that took the N-th strobe.
- R7: Access strobes that arrive while no request is pending and no burst is in progress are ignored. They do not shorten the next burst.
- R8: When `chanEn` is 0 at a clock edge, both requests are 0 after that edge and any burst in progress is discarded. After the channel is re-enabled, a request can rise again without further accesses.
- R9: While `rstN` is 0 at a clock edge (synchronous, active low), both requests are 0 after that edge and all burst state returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| chanEn | input | 1 | Channel enable |
| rdDmaEn | input | 1 | Read request mask (1 = request allowed) |
| wrDmaEn | input | 1 | Write request mask (1 = request allowed) |
| rxLevelBytes | input | LVL_W | Receive trigger level in bytes (almost full) |
| txLevelBytes | input | LVL_W | Transmit trigger level in bytes (almost empty) |
| rxOccBytes | input | LVL_W | Bytes currently held in the receive FIFO |
| txOccBytes | input | LVL_W | Bytes currently held in the transmit FIFO |
| rxWordRead | input | 1 | One-cycle strobe: one word read from the receive FIFO |
| txWordWritten | input | 1 | One-cycle strobe: one word written into the transmit FIFO |
| dmaRdReq | output | 1 | DMA read request, registered |
| dmaWrReq | output | 1 | DMA write request, registered |

## Verification
Both request lines are registered, so every effect of a stimulus shows after exactly one clock edge:

- A trigger condition raises its request after one edge.
- A service strobe, a cleared mask, a disable or a reset drops the request at the edge that samples it.
- The end of a burst brings the request back only on the second edge after the final strobe, because the burst state first returns to idle.

The bench changes inputs on the falling edge and samples the outputs one full cycle later, on the next falling edge. Every expected value therefore refers to exactly one rising edge. The blocking window is checked at every cycle of the burst, so a request that comes back early or late is caught.

// File: rtl/spi_dma_pkg.sv
package spi_dma_pkg;

  // Commands from the control FSM to the burst datapath
  typedef struct packed {
    logic load;   // start a burst: remaining = burst words - 1
    logic dec;    // one more access of the burst serviced
    logic clr;    // discard burst state
  } cnt_cmd_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_HOLD = 2'd2
  } req_state_e;

endpackage

// File: rtl/spi_dma_burst_dp.sv
module spi_dma_burst_dp
  import spi_dma_pkg::*;
#(
  parameter int LVL_W      = 7,
  parameter int WORD_BYTES = 4,
  parameter bit IS_RX      = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  cnt_cmd_t         cmd,
  input  logic [LVL_W-1:0] levelBytes,
  input  logic [LVL_W-1:0] occBytes,
  output logic             condMet,
  output logic             burstOne,
  output logic             cntLast
);

  localparam int EXT_W = LVL_W + 1;

  logic [EXT_W-1:0] roundedWords;
  logic [LVL_W-1:0] burstWords;
  logic [LVL_W-1:0] remaining;

  // Convert the byte level to words, rounding up, never below one word
  always_comb begin
    roundedWords = ({1'b0, levelBytes} + EXT_W'(WORD_BYTES - 1)) / EXT_W'(WORD_BYTES);
    if (roundedWords == '0) burstWords = LVL_W'(1);
    else                    burstWords = roundedWords[LVL_W-1:0];
  end

  // Trigger comparison: receive side waits for fill, transmit side for drain
  generate
    if (IS_RX) begin : g_rxCmp
      assign condMet = (occBytes >= levelBytes);
    end else begin : g_txCmp
      assign condMet = (occBytes < levelBytes);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remaining <= '0;
    end else if (cmd.clr) begin
      remaining <= '0;
    end else if (cmd.load) begin
      remaining <= burstWords - LVL_W'(1);
    end else if (cmd.dec) begin
      remaining <= remaining - LVL_W'(1);
    end
  end

  assign burstOne = (burstWords == LVL_W'(1));
  assign cntLast  = (remaining == LVL_W'(1));

endmodule

// File: rtl/spi_dma_req_ctrl.sv
module spi_dma_req_ctrl
  import spi_dma_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     chanEn,
  input  logic     maskEn,
  input  logic     condMet,
  input  logic     burstOne,
  input  logic     cntLast,
  input  logic     accessDone,
  output cnt_cmd_t cmd,
  output logic     reqOut
);

  req_state_e state;
  req_state_e stateNext;

  always_comb begin
    cmd       = '0;
    stateNext = state;
    if (!chanEn) begin
      stateNext = ST_IDLE;
      cmd.clr   = 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          // strobes here are not part of any burst and are dropped
          if (maskEn && condMet) stateNext = ST_REQ;
        end
        ST_REQ: begin
          if (accessDone) begin
            cmd.load  = 1'b1;
            stateNext = burstOne ? ST_IDLE : ST_HOLD;
          end else if (!maskEn) begin
            stateNext = ST_IDLE;
          end
        end
        ST_HOLD: begin
          if (accessDone) begin
            if (cntLast) begin
              cmd.clr   = 1'b1;
              stateNext = ST_IDLE;
            end else begin
              cmd.dec   = 1'b1;
            end
          end
        end
        default: begin
          stateNext = ST_IDLE;
          cmd.clr   = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      reqOut <= 1'b0;
    end else begin
      state  <= stateNext;
      reqOut <= (stateNext == ST_REQ);
    end
  end

endmodule

// File: rtl/spi_dma_req_gen.sv
module spi_dma_req_gen
  import spi_dma_pkg::*;
#(
  parameter int FIFO_BYTES = 64,
  parameter int WORD_BYTES = 4,
  parameter int LVL_W      = $clog2(FIFO_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             chanEn,
  input  logic             rdDmaEn,
  input  logic             wrDmaEn,
  input  logic [LVL_W-1:0] rxLevelBytes,
  input  logic [LVL_W-1:0] txLevelBytes,
  input  logic [LVL_W-1:0] rxOccBytes,
  input  logic [LVL_W-1:0] txOccBytes,
  input  logic             rxWordRead,
  input  logic             txWordWritten,
  output logic             dmaRdReq,
  output logic             dmaWrReq
);

  localparam int NUM_DIR = 2;   // index 0: receive/read, 1: transmit/write

  logic [NUM_DIR-1:0]            maskV;
  logic [NUM_DIR-1:0]            accessV;
  logic [NUM_DIR-1:0]            reqV;
  logic [NUM_DIR-1:0][LVL_W-1:0] levelV;
  logic [NUM_DIR-1:0][LVL_W-1:0] occV;

  assign maskV   = {wrDmaEn, rdDmaEn};
  assign accessV = {txWordWritten, rxWordRead};
  assign levelV  = {txLevelBytes, rxLevelBytes};
  assign occV    = {txOccBytes, rxOccBytes};

  generate
    for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
      cnt_cmd_t cmd;
      logic     condMet;
      logic     burstOne;
      logic     cntLast;

      spi_dma_burst_dp #(
        .LVL_W      (LVL_W),
        .WORD_BYTES (WORD_BYTES),
        .IS_RX      (d == 0)
      ) u_dp (
        .clk        (clk),
        .rstN       (rstN),
        .cmd        (cmd),
        .levelBytes (levelV[d]),
        .occBytes   (occV[d]),
        .condMet    (condMet),
        .burstOne   (burstOne),
        .cntLast    (cntLast)
      );

      spi_dma_req_ctrl u_ctrl (
        .clk        (clk),
        .rstN       (rstN),
        .chanEn     (chanEn),
        .maskEn     (maskV[d]),
        .condMet    (condMet),
        .burstOne   (burstOne),
        .cntLast    (cntLast),
        .accessDone (accessV[d]),
        .cmd        (cmd),
        .reqOut     (reqV[d])
      );
    end
  endgenerate

  assign dmaRdReq = reqV[0];
  assign dmaWrReq = reqV[1];

endmodule

// File: rtl/spi_dma_req_gen_chk.sv
module spi_dma_req_gen_chk #(
  parameter int LVL_W = 7
) (
  input logic             clk,
  input logic             rstN,
  input logic             chanEn,
  input logic             rdDmaEn,
  input logic             wrDmaEn,
  input logic [LVL_W-1:0] rxLevelBytes,
  input logic [LVL_W-1:0] txLevelBytes,
  input logic [LVL_W-1:0] rxOccBytes,
  input logic [LVL_W-1:0] txOccBytes,
  input logic             rxWordRead,
  input logic             txWordWritten,
  input logic             dmaRdReq,
  input logic             dmaWrReq
);

  // R1
  rd_rise_cond_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dmaRdReq) |-> $past(chanEn && rdDmaEn && (rxOccBytes >= rxLevelBytes)));

  // R2
  wr_rise_cond_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dmaWrReq) |-> $past(chanEn && wrDmaEn && (txOccBytes < txLevelBytes)));

  // R3
  rd_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdDmaEn |=> !dmaRdReq);

  // R3
  wr_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrDmaEn |=> !dmaWrReq);

  // R4
  rd_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dmaRdReq && rxWordRead) |=> !dmaRdReq);

  // R5
  wr_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dmaWrReq && txWordWritten) |=> !dmaWrReq);

  // R8
  disable_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !chanEn |=> (!dmaRdReq && !dmaWrReq));

  // R9
  reset_idle_chk: assert property (@(posedge clk)
    !rstN |=> (!dmaRdReq && !dmaWrReq));

endmodule

bind spi_dma_req_gen spi_dma_req_gen_chk #(.LVL_W(LVL_W)) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .chanEn        (chanEn),
  .rdDmaEn       (rdDmaEn),
  .wrDmaEn       (wrDmaEn),
  .rxLevelBytes  (rxLevelBytes),
  .txLevelBytes  (txLevelBytes),
  .rxOccBytes    (rxOccBytes),
  .txOccBytes    (txOccBytes),
  .rxWordRead    (rxWordRead),
  .txWordWritten (txWordWritten),
  .dmaRdReq      (dmaRdReq),
  .dmaWrReq      (dmaWrReq)
);

// File: tb/spi_dma_req_gen_bench.sv
module spi_dma_req_gen_bench;

  localparam int CLK_PERIOD = 10;
  localparam int LVL_W      = 7;
  localparam int NVEC       = 16;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             chanEn = 1'b0;
  logic             rdDmaEn = 1'b0;
  logic             wrDmaEn = 1'b0;
  logic [LVL_W-1:0] rxLevelBytes = '0;
  logic [LVL_W-1:0] txLevelBytes = '0;
  logic [LVL_W-1:0] rxOccBytes = '0;
  logic [LVL_W-1:0] txOccBytes = '0;
  logic             rxWordRead = 1'b0;
  logic             txWordWritten = 1'b0;
  logic             dmaRdReq;
  logic             dmaWrReq;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_dma_req_gen #(.FIFO_BYTES(64), .WORD_BYTES(4)) u_spi_dma_req_gen (
    .clk           (clk),
    .rstN          (rstN),
    .chanEn        (chanEn),
    .rdDmaEn       (rdDmaEn),
    .wrDmaEn       (wrDmaEn),
    .rxLevelBytes  (rxLevelBytes),
    .txLevelBytes  (txLevelBytes),
    .rxOccBytes    (rxOccBytes),
    .txOccBytes    (txOccBytes),
    .rxWordRead    (rxWordRead),
    .txWordWritten (txWordWritten),
    .dmaRdReq      (dmaRdReq),
    .dmaWrReq      (dmaWrReq)
  );

  typedef struct packed {
    logic             en;
    logic             rm;
    logic             wm;
    logic [LVL_W-1:0] rxLvl;
    logic [LVL_W-1:0] txLvl;
    logic [LVL_W-1:0] rxOcc;
    logic [LVL_W-1:0] txOcc;
    logic             rd;
    logic             wr;
    logic             expRd;
    logic             expWr;
  } vec_t;

  // Word size 4 bytes: rx level 8 -> 2-word burst, tx level 12 -> 3-word burst
  localparam vec_t VEC [NVEC] = '{
    '{1'b1,1'b1,1'b1, 7'd8,7'd12, 7'd0, 7'd16, 1'b0,1'b0, 1'b0,1'b0}, // 0 nothing due
    '{1'b1,1'b1,1'b1, 7'd8,7'd12, 7'd8, 7'd16, 1'b0,1'b0, 1'b1,1'b0}, // 1 R1 rx reaches level
    '{1'b1,1'b1,1'b1, 7'd8,7'd12, 7'd8, 7'd16, 1'b1,1'b0, 1'b0,1'b0}, // 2 R4 first read drops
    '{1'b1,1'b1,1'b1, 7'd8,7'd12, 7'd8, 7'd16, 1'b0,1'b0, 1'b0,1'b0}, // 3 R6 blocked
    '{1'b1,1'b1,1'b1, 7'd8,7'd12, 7'd8, 7'd16, 1'b1,1'b0, 1'b0,1'b0}, // 4 R6 last read
    '{1'b1,1'b1,1'b1, 7'd8,7'd12, 7'd8, 7'd16, 1'b0,1'b0, 1'b1,1'b0}, // 5 R6 re-raised
    '{1'b1,1'b1,1'b1, 7'd8,7'd12, 7'd0, 7'd4,  1'b1,1'b0, 1'b0,1'b1}, // 6 R4 and R2
    '{1'b1,1'b1,1'b1, 7'd8,7'd12, 7'd0, 7'd4,  1'b1,1'b1, 1'b0,1'b0}, // 7 R5 first write drops
    '{1'b1,1'b1,1'b1, 7'd8,7'd12, 7'd0, 7'd4,  1'b0,1'b1, 1'b0,1'b0}, // 8 R6 second write
    '{1'b1,1'b1,1'b1, 7'd8,7'd12, 7'd0, 7'd4,  1'b0,1'b0, 1'b0,1'b0}, // 9 R6 still blocked
    '{1'b1,1'b1,1'b1, 7'd8,7'd12, 7'd0, 7'd4,  1'b0,1'b1, 1'b0,1'b0}, // 10 R6 third write
    '{1'b1,1'b1,1'b1, 7'd8,7'd12, 7'd0, 7'd4,  1'b0,1'b0, 1'b0,1'b1}, // 11 R6 re-raised
    '{1'b1,1'b1,1'b0, 7'd8,7'd12, 7'd0, 7'd4,  1'b0,1'b0, 1'b0,1'b0}, // 12 R3 mask withdraws
    '{1'b1,1'b1,1'b0, 7'd8,7'd12, 7'd0, 7'd4,  1'b0,1'b0, 1'b0,1'b0}, // 13 R3 stays low
    '{1'b1,1'b1,1'b1, 7'd8,7'd12, 7'd0, 7'd4,  1'b0,1'b0, 1'b0,1'b1}, // 14 R2 unmasked again
    '{1'b0,1'b1,1'b1, 7'd8,7'd12, 7'd8, 7'd4,  1'b0,1'b0, 1'b0,1'b0}  // 15 R8 disabled
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idleInputs();
    chanEn = 1'b1; rdDmaEn = 1'b1; wrDmaEn = 1'b1;
    rxLevelBytes = '0; txLevelBytes = '0; rxOccBytes = '0; txOccBytes = 7'd64;
    rxWordRead = 1'b0; txWordWritten = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R9: reset state
    @(negedge clk);
    chanEn = 1'b1; rdDmaEn = 1'b1; rxOccBytes = 7'd64;
    tick(); tick();
    chk("R9 reset rd", dmaRdReq, 1'b0);
    chk("R9 reset wr", dmaWrReq, 1'b0);
    rstN = 1'b1;

    // Table walk
    for (int i = 0; i < NVEC; i++) begin
      chanEn = VEC[i].en; rdDmaEn = VEC[i].rm; wrDmaEn = VEC[i].wm;
      rxLevelBytes = VEC[i].rxLvl; txLevelBytes = VEC[i].txLvl;
      rxOccBytes = VEC[i].rxOcc; txOccBytes = VEC[i].txOcc;
      rxWordRead = VEC[i].rd; txWordWritten = VEC[i].wr;
      tick();
      chk($sformatf("R1 R2 R3 R4 R5 R6 R8 table %0d rd", i), dmaRdReq, VEC[i].expRd);
      chk($sformatf("R1 R2 R3 R4 R5 R6 R8 table %0d wr", i), dmaWrReq, VEC[i].expWr);
    end

    // R1/R2 boundaries: one byte short of the trigger
    idleInputs();
    rxLevelBytes = 7'd8; rxOccBytes = 7'd7; txLevelBytes = 7'd12; txOccBytes = 7'd12;
    tick(); tick();
    chk("R1 rx one byte short", dmaRdReq, 1'b0);
    chk("R2 tx equal to level", dmaWrReq, 1'b0);
    txOccBytes = 7'd11;
    tick();
    chk("R2 tx one below level", dmaWrReq, 1'b1);

    // R7: strobes while idle do not count toward the next burst
    idleInputs();
    chanEn = 1'b0; tick(); chanEn = 1'b1;
    rxLevelBytes = 7'd8; rxOccBytes = 7'd0;
    for (int k = 0; k < 3; k++) begin
      rxWordRead = 1'b1; tick();
    end
    rxWordRead = 1'b0; rxOccBytes = 7'd8;
    tick();
    chk("R7 rd raised after idle strobes", dmaRdReq, 1'b1);
    rxWordRead = 1'b1; tick(); rxWordRead = 1'b0;
    chk("R7 rd dropped", dmaRdReq, 1'b0);
    tick(); tick();
    chk("R7 rd still blocked, burst not shortened", dmaRdReq, 1'b0);
    rxWordRead = 1'b1; tick(); rxWordRead = 1'b0;
    tick();
    chk("R7 rd back after full burst", dmaRdReq, 1'b1);

    // R6: rounding up, level 5 bytes -> 2 words
    idleInputs();
    chanEn = 1'b0; tick(); chanEn = 1'b1;
    rxLevelBytes = 7'd5; rxOccBytes = 7'd5;
    tick();
    chk("R6 rd raised level 5", dmaRdReq, 1'b1);
    rxWordRead = 1'b1; tick(); rxWordRead = 1'b0;
    tick();
    chk("R6 rounded burst still blocking", dmaRdReq, 1'b0);
    rxWordRead = 1'b1; tick(); rxWordRead = 1'b0;
    chk("R6 low on last-access edge", dmaRdReq, 1'b0);
    tick();
    chk("R6 re-raised two edges after last access", dmaRdReq, 1'b1);

    // R6: level 0 -> minimum burst of one word
    rxLevelBytes = 7'd0; rxOccBytes = 7'd0;
    rxWordRead = 1'b1; tick(); rxWordRead = 1'b0;
    chk("R6 level 0 dropped", dmaRdReq, 1'b0);
    tick();
    chk("R6 level 0 one-word burst", dmaRdReq, 1'b1);

    // R6: full FIFO level -> 16 words
    chanEn = 1'b0; tick(); chanEn = 1'b1;
    rxLevelBytes = 7'd64; rxOccBytes = 7'd64;
    tick();
    chk("R6 rd raised level 64", dmaRdReq, 1'b1);
    for (int k = 0; k < 15; k++) begin
      rxWordRead = 1'b1; tick();
      chk($sformatf("R6 long burst blocked after access %0d", k + 1), dmaRdReq, 1'b0);
    end
    rxWordRead = 1'b1; tick(); rxWordRead = 1'b0;
    chk("R6 long burst last access", dmaRdReq, 1'b0);
    tick();
    chk("R6 long burst re-raised", dmaRdReq, 1'b1);

    // R8: disable during a burst discards it
    rxLevelBytes = 7'd8; rxOccBytes = 7'd8;
    rxWordRead = 1'b1; tick(); rxWordRead = 1'b0;
    chk("R8 rd dropped into burst", dmaRdReq, 1'b0);
    chanEn = 1'b0; tick();
    chk("R8 rd low while disabled", dmaRdReq, 1'b0);
    chanEn = 1'b1; tick();
    chk("R8 rd raised without finishing old burst", dmaRdReq, 1'b1);

    // R2: write level 0 never requests
    idleInputs();
    txLevelBytes = 7'd0; txOccBytes = 7'd0;
    for (int k = 0; k < 4; k++) begin
      tick();
      chk("R2 tx level 0 never requests", dmaWrReq, 1'b0);
    end

    // R9: reset in the middle of a pending request
    txLevelBytes = 7'd12; txOccBytes = 7'd4;
    tick();
    chk("R9 wr pending before reset", dmaWrReq, 1'b1);
    rstN = 1'b0; tick();
    chk("R9 wr cleared by reset", dmaWrReq, 1'b0);
    rstN = 1'b1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule